// File: doc/BRIEF.md
# Presence-Detect Timing Extractor

This block reads the 256-byte configuration image that a memory module carries and prepares it for a memory controller. The image arrives as a byte stream, at most one byte per clock. Each byte comes with a valid strobe, its index within the image, and a marker on the final byte.

While the image streams in, the block does three things:

- It keeps a running modulo-256 sum of the leading bytes.
- It records the memory-type byte.
- It latches the three geometry bytes: row address bits, column address bits and internal banks.

After the final byte, eight timing bytes are converted into whole controller clock counts, always rounded up. The controller clock period is a build-time parameter, given in tenths of a nanosecond. Each count comes from its own small divider that works by repeated subtraction. When every divider has finished, `done` rises, together with a checksum-error flag and a type-error flag.

A controller uses the block at start-up. It streams the image, waits for `done`, then programs its timing counters from the count outputs and rejects the module if either flag is high.

Top module: `spd_timing_extract`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `done`, both flags, the three geometry outputs and all eight clock counts are zero.
- R2: The module adds bytes 0 to 62 modulo 256 and compares the result with byte 63. When `done` rises, `csum_err` is 1 exactly when the two differ. Neither flag is ever high while `done` is low.
- R3: When `done` rises, `type_err` is 1 exactly when byte 2 was not 07h.
- R4: `row_bits`, `col_bits` and `bank_count` carry bytes 3, 4 and 17 unchanged. They change only on a cycle that follows an accepted byte.
- R5: Bytes 9 and 23 each encode a time as the upper nibble in whole ns plus the lower nibble in tenths of ns (75h is 7.5 ns, A0h is 10 ns). They drive `cyc_main_clk` (byte 9) and `cyc_alt_clk` (byte 23).
- R6: Bytes 27, 28 and 29 each count quarter nanoseconds (50h is 20 ns). They drive `prech_clk`, `act2act_clk` and `ras2cas_clk`, in that order.
- R7: Bytes 30, 41 and 42 each count whole nanoseconds. They drive `act_min_clk`, `row_cycle_clk` and `refresh_clk`, in that order.
- R8: Each count is the time divided by the clock period, rounded up to the next integer. An exact ratio is not rounded, and a zero byte gives 0. For example, at 7.5 ns, 20 ns gives 3 and 15 ns gives 2.
- R9: `done` rises at most 40 cycles after a final byte, provided byte 63 has arrived in the current image (the final byte may itself be byte 63). If the image ends before byte 63, `done` stays low.
- R10: Once high, `done` and the flags hold until an accepted byte with index 0 starts a new image. The cycle after that byte, `done` is low.
- R11: Bytes 64 to 255 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | A byte is offered this cycle |
| byte_index | input | 8 | Position of the byte in the image |
| byte_data | input | 8 | Byte value |
| byte_last | input | 1 | This byte ends the image |
| done | output | 1 | Conversions finished, outputs valid |
| csum_err | output | 1 | Stored checksum did not match |
| type_err | output | 1 | Memory type byte was not 07h |
| row_bits | output | 8 | Row address bit count (byte 3) |
| col_bits | output | 8 | Column address bit count (byte 4) |
| bank_count | output | 8 | Banks per device (byte 17) |
| cyc_main_clk | output | CNT_W | Clocks for byte 9 |
| cyc_alt_clk | output | CNT_W | Clocks for byte 23 |
| prech_clk | output | CNT_W | Clocks for byte 27 |
| act2act_clk | output | CNT_W | Clocks for byte 28 |
| ras2cas_clk | output | CNT_W | Clocks for byte 29 |
| act_min_clk | output | CNT_W | Clocks for byte 30 |
| row_cycle_clk | output | CNT_W | Clocks for byte 41 |
| refresh_clk | output | CNT_W | Clocks for byte 42 |

## Verification
Each kind of internal fault shows up at the ports in its own way:

- **Sum register.** A sum that wraps wrongly, or that includes byte 63 or a byte above it, shows as a wrong `csum_err` in the very cycle `done` rises.
- **Timing-byte capture.** A timing byte stored in the wrong slot, or decoded under the wrong encoding, shows as a count that is off by one or more when `done` rises.
- **Subtraction loop.** A loop that stops one step early or late gives a count that is off by one, most often on exact ratios, or a `done` that never comes within the expected window.
- **Restart logic.** A stale index-0 clear or a missing byte-63 guard shows as `done` rising after a short image, or as `done` still high one cycle after a new image begins.

// File: rtl/spd_extract_pkg.sv
// Shared constants, types and decode helpers for the presence-detect
// timing extractor. Times are carried in units of 0.05 ns so that the
// tenth-ns and quarter-ns encodings are both exact integers.
package spd_extract_pkg;

    localparam int VAL_W  = 14;   // holds 255 ns in 0.05 ns units (5100)
    localparam int NUM_T  = 8;    // number of timing bytes converted

    typedef enum logic [1:0] {
        ENC_NIBBLE  = 2'd0,       // upper nibble ns, lower nibble tenths
        ENC_QUARTER = 2'd1,       // count of 0.25 ns
        ENC_WHOLE   = 2'd2        // count of 1 ns
    } tenc_e;

    // Map a byte index to {hit, slot}; slot order fixes the output order.
    function automatic logic [3:0] slot_of(logic [7:0] idx);
        case (idx)
            8'd9:    return 4'b1000;
            8'd23:   return 4'b1001;
            8'd27:   return 4'b1010;
            8'd28:   return 4'b1011;
            8'd29:   return 4'b1100;
            8'd30:   return 4'b1101;
            8'd41:   return 4'b1110;
            8'd42:   return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    // Encoding used by each slot.
    function automatic tenc_e enc_of(int slot);
        if (slot < 2)      return ENC_NIBBLE;
        else if (slot < 5) return ENC_QUARTER;
        else               return ENC_WHOLE;
    endfunction

    // Convert a raw byte to 0.05 ns units under the given encoding.
    function automatic logic [VAL_W-1:0] to_units(tenc_e e, logic [7:0] b);
        logic [VAL_W-1:0] hi, lo, whole;
        hi    = VAL_W'(b[7:4]);
        lo    = VAL_W'(b[3:0]);
        whole = VAL_W'(b);
        case (e)
            ENC_NIBBLE:  return (hi * VAL_W'(10) + lo) * VAL_W'(2);
            ENC_QUARTER: return whole * VAL_W'(5);
            default:     return whole * VAL_W'(20);
        endcase
    endfunction

endpackage

// File: rtl/spd_image_capture.sv
// Byte-stream front end. Keeps the modulo-256 sum of bytes 0..62,
// stores byte 63, the type byte, the geometry bytes and the raw timing
// bytes. Issues a one-cycle start pulse the cycle after a final byte,
// but only if byte 63 belongs to the current image.
// Assumes bytes of one image arrive with index 0 first.
module spd_image_capture
    import spd_extract_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_index,
    input  logic [7:0] byte_data,
    input  logic       byte_last,
    output logic       start,
    output logic       seen_csum,
    output logic       sum_ok,
    output logic       type_ok,
    output logic [7:0] row_bits,
    output logic [7:0] col_bits,
    output logic [7:0] bank_count,
    output logic [7:0] raw [NUM_T]
);

    logic [7:0] run_sum;
    logic [7:0] stored_sum;
    logic [7:0] type_byte;
    logic [3:0] slot_info;

    assign slot_info = slot_of(byte_index);

    // Running sum of the checksum-covered range, restarted at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_sum <= '0;
        else if (byte_valid && byte_index == 8'd0)
            run_sum <= byte_data;
        else if (byte_valid && byte_index < 8'd63)
            run_sum <= run_sum + byte_data;
    end

    // Stored checksum and the flag saying it belongs to this image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_sum <= '0;
            seen_csum  <= 1'b0;
        end else if (byte_valid && byte_index == 8'd63) begin
            stored_sum <= byte_data;
            seen_csum  <= 1'b1;
        end else if (byte_valid && byte_index == 8'd0) begin
            seen_csum  <= 1'b0;
        end
    end

    // Type and geometry bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_byte  <= '0;
            row_bits   <= '0;
            col_bits   <= '0;
            bank_count <= '0;
        end else if (byte_valid) begin
            case (byte_index)
                8'd2:    type_byte  <= byte_data;
                8'd3:    row_bits   <= byte_data;
                8'd4:    col_bits   <= byte_data;
                8'd17:   bank_count <= byte_data;
                default: ;
            endcase
        end
    end

    // One holding register per timing slot.
    for (genvar s = 0; s < NUM_T; s++) begin : g_raw
        always_ff @(posedge clk) begin
            if (!rst_n)
                raw[s] <= '0;
            else if (byte_valid && slot_info[3] && slot_info[2:0] == 3'(s))
                raw[s] <= byte_data;
        end
    end

    // Start pulse one cycle after a final byte of a complete-enough image.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start <= 1'b0;
        else
            start <= byte_valid && byte_last &&
                     (seen_csum || byte_index == 8'd63);
    end

    assign sum_ok  = (run_sum == stored_sum);
    assign type_ok = (type_byte == 8'h07);

endmodule

// File: rtl/spd_ceil_div.sv
// Round-up divider by repeated subtraction of a constant divisor.
// On start it loads the dividend; each busy cycle adds one to the count
// and removes one divisor. Finishes after ceil(dividend/DIVISOR) busy
// cycles. A zero dividend finishes at once with count 0.
// Assumes the quotient fits in CNT_W bits.
module spd_ceil_div #(
    parameter int VAL_W   = 14,
    parameter int CNT_W   = 8,
    parameter int DIVISOR = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VAL_W-1:0] dividend,
    output logic [CNT_W-1:0] result,
    output logic             busy
);

    localparam logic [VAL_W-1:0] DIV_V = VAL_W'(DIVISOR);

    logic [VAL_W-1:0] remain;

    // Load on start, then subtract until the remainder is covered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            result <= '0;
            busy   <= 1'b0;
        end else if (start) begin
            remain <= dividend;
            result <= '0;
            busy   <= (dividend != '0);
        end else if (busy) begin
            result <= result + CNT_W'(1);
            if (remain > DIV_V)
                remain <= remain - DIV_V;
            else
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/spd_timing_extract.sv
// Top level of the presence-detect timing extractor. Captures the
// stream, converts eight timing bytes to controller clocks in parallel
// dividers, and raises done with the checksum and type verdicts.
// CLK_TENTHS is the controller clock period in tenths of a ns; it must
// be at least 10 so that the default CNT_W holds every count.
module spd_timing_extract
    import spd_extract_pkg::*;
#(
    parameter int CLK_TENTHS = 75,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_index,
    input  logic [7:0]       byte_data,
    input  logic             byte_last,
    output logic             done,
    output logic             csum_err,
    output logic             type_err,
    output logic [7:0]       row_bits,
    output logic [7:0]       col_bits,
    output logic [7:0]       bank_count,
    output logic [CNT_W-1:0] cyc_main_clk,
    output logic [CNT_W-1:0] cyc_alt_clk,
    output logic [CNT_W-1:0] prech_clk,
    output logic [CNT_W-1:0] act2act_clk,
    output logic [CNT_W-1:0] ras2cas_clk,
    output logic [CNT_W-1:0] act_min_clk,
    output logic [CNT_W-1:0] row_cycle_clk,
    output logic [CNT_W-1:0] refresh_clk
);

    localparam int DIVISOR_U = 2 * CLK_TENTHS;   // period in 0.05 ns units

    logic             start;
    logic             seen_csum;
    logic             sum_ok;
    logic             type_ok;
    logic             conv_active;
    logic [7:0]       raw  [NUM_T];
    logic [VAL_W-1:0] dvd  [NUM_T];
    logic [CNT_W-1:0] cnt  [NUM_T];
    logic [NUM_T-1:0] busy;

    spd_image_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_index (byte_index),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .start      (start),
        .seen_csum  (seen_csum),
        .sum_ok     (sum_ok),
        .type_ok    (type_ok),
        .row_bits   (row_bits),
        .col_bits   (col_bits),
        .bank_count (bank_count),
        .raw        (raw)
    );

    // One decoder and divider per timing slot.
    for (genvar s = 0; s < NUM_T; s++) begin : g_conv
        assign dvd[s] = to_units(enc_of(s), raw[s]);

        spd_ceil_div #(
            .VAL_W   (VAL_W),
            .CNT_W   (CNT_W),
            .DIVISOR (DIVISOR_U)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start),
            .dividend (dvd[s]),
            .result   (cnt[s]),
            .busy     (busy[s])
        );
    end

    // Completion tracking and verdict flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_active <= 1'b0;
            done        <= 1'b0;
            csum_err    <= 1'b0;
            type_err    <= 1'b0;
        end else if (byte_valid && byte_index == 8'd0) begin
            conv_active <= 1'b0;
            done        <= 1'b0;
            csum_err    <= 1'b0;
            type_err    <= 1'b0;
        end else if (start) begin
            conv_active <= 1'b1;
            done        <= 1'b0;
        end else if (conv_active && busy == '0) begin
            conv_active <= 1'b0;
            done        <= 1'b1;
            csum_err    <= !sum_ok;
            type_err    <= !type_ok;
        end
    end

    assign cyc_main_clk  = cnt[0];
    assign cyc_alt_clk   = cnt[1];
    assign prech_clk     = cnt[2];
    assign act2act_clk   = cnt[3];
    assign ras2cas_clk   = cnt[4];
    assign act_min_clk   = cnt[5];
    assign row_cycle_clk = cnt[6];
    assign refresh_clk   = cnt[7];

endmodule

// File: rtl/spd_timing_checker.sv
// Assertion checker for the presence-detect timing extractor, bound to
// the top level. Relates the verdict register, the capture front end
// and the dividers over time.
module spd_timing_checker #(
    parameter int VAL_W   = 14,
    parameter int CNT_W   = 8,
    parameter int DIVISOR = 150
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic [7:0]       byte_index,
    input logic             done,
    input logic             csum_err,
    input logic             type_err,
    input logic             seen_csum,
    input logic [7:0]       row_bits,
    input logic [7:0]       col_bits,
    input logic [7:0]       bank_count,
    input logic [VAL_W-1:0] dvd_a,
    input logic [CNT_W-1:0] cnt_a,
    input logic [VAL_W-1:0] dvd_b,
    input logic [CNT_W-1:0] cnt_b
);

    // R2 and R3: a verdict flag is only ever shown together with done.
    assert_flags_need_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csum_err || type_err) |-> done);

    // R9: done can only rise for an image that delivered byte 63.
    assert_done_needs_csum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> seen_csum);

    // R10: done holds until a new image begins.
    assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(byte_valid && byte_index == 8'd0)) |=> done);

    // R10: an index-0 byte clears done on the next cycle.
    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_index == 8'd0) |=> !done);

    // R4: geometry outputs move only after an accepted byte.
    assert_geom_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable({row_bits, col_bits, bank_count}));

    // R8: quarter-ns slot count is the rounded-up quotient.
    assert_ceil_quarter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (int'(cnt_a) * DIVISOR >= int'(dvd_a)) &&
                        (cnt_a == '0 || (int'(cnt_a) - 1) * DIVISOR < int'(dvd_a)));

    // R8: whole-ns slot count is the rounded-up quotient.
    assert_ceil_whole_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (int'(cnt_b) * DIVISOR >= int'(dvd_b)) &&
                        (cnt_b == '0 || (int'(cnt_b) - 1) * DIVISOR < int'(dvd_b)));

endmodule

bind spd_timing_extract spd_timing_checker #(
    .VAL_W   (spd_extract_pkg::VAL_W),
    .CNT_W   (CNT_W),
    .DIVISOR (DIVISOR_U)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_index (byte_index),
    .done       (done),
    .csum_err   (csum_err),
    .type_err   (type_err),
    .seen_csum  (seen_csum),
    .row_bits   (row_bits),
    .col_bits   (col_bits),
    .bank_count (bank_count),
    .dvd_a      (dvd[2]),
    .cnt_a      (cnt[2]),
    .dvd_b      (dvd[7]),
    .cnt_b      (cnt[7])
);

// File: tb/tb_spd_timing_extract.sv
// Self-checking bench: a table of images with expected verdicts, then
// directed tests for reset, upper-area bytes, restart and short images.
module tb_spd_timing_extract;

    localparam int CLK_TENTHS = 75;
    localparam int CNT_W      = 8;

    typedef struct packed {
        logic [7:0]  b2;
        logic [7:0]  b3;
        logic [7:0]  b4;
        logic [7:0]  b17;
        logic [63:0] tbytes;    // slot 0 in bits 63:56
        logic        good_sum;
        logic        exp_csum_err;
        logic        exp_type_err;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'h07, 8'h0C, 8'h0A, 8'h04, 64'h7575_503C_502D_414B, 1'b1, 1'b0, 1'b0},
        '{8'h07, 8'h0D, 8'h0B, 8'h08, 64'h80A0_503C_5032_4650, 1'b0, 1'b1, 1'b0},
        '{8'h04, 8'h0B, 8'h09, 8'h02, 64'h00FF_01FF_3C00_FF01, 1'b1, 1'b0, 1'b1},
        '{8'h07, 8'h0E, 8'h0A, 8'h04, 64'h0FF0_1E3C_5A0F_4B96, 1'b1, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             byte_valid;
    logic [7:0]       byte_index;
    logic [7:0]       byte_data;
    logic             byte_last;
    logic             done, csum_err, type_err;
    logic [7:0]       row_bits, col_bits, bank_count;
    logic [CNT_W-1:0] cyc_main_clk, cyc_alt_clk, prech_clk, act2act_clk;
    logic [CNT_W-1:0] ras2cas_clk, act_min_clk, row_cycle_clk, refresh_clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [7:0] img [256];

    always #2 clk = ~clk;

    spd_timing_extract #(.CLK_TENTHS(CLK_TENTHS), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid),
        .byte_index(byte_index), .byte_data(byte_data), .byte_last(byte_last),
        .done(done), .csum_err(csum_err), .type_err(type_err),
        .row_bits(row_bits), .col_bits(col_bits), .bank_count(bank_count),
        .cyc_main_clk(cyc_main_clk), .cyc_alt_clk(cyc_alt_clk),
        .prech_clk(prech_clk), .act2act_clk(act2act_clk),
        .ras2cas_clk(ras2cas_clk), .act_min_clk(act_min_clk),
        .row_cycle_clk(row_cycle_clk), .refresh_clk(refresh_clk)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog R9: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int slot_index(input int s);
        case (s)
            0: return 9;   1: return 23;  2: return 27;  3: return 28;
            4: return 29;  5: return 30;  6: return 41;  default: return 42;
        endcase
    endfunction

    // Expected clocks: time in hundredths of ns, divided up by the period.
    function automatic int exp_clk(input int s, input int b);
        int hund;
        if (s < 2)      hund = ((b / 16) * 10 + (b % 16)) * 10;
        else if (s < 5) hund = b * 25;
        else            hund = b * 100;
        return (hund + CLK_TENTHS * 10 - 1) / (CLK_TENTHS * 10);
    endfunction

    function automatic int got_clk(input int s);
        case (s)
            0: return int'(cyc_main_clk);  1: return int'(cyc_alt_clk);
            2: return int'(prech_clk);     3: return int'(act2act_clk);
            4: return int'(ras2cas_clk);   5: return int'(act_min_clk);
            6: return int'(row_cycle_clk); default: return int'(refresh_clk);
        endcase
    endfunction

    function automatic string slot_req(input int s);
        if (s < 2)      return "R5";
        else if (s < 5) return "R6";
        else            return "R7";
    endfunction

    // Fill an image; seed only alters bytes 64..255.
    task automatic build(input vec_t v, input int seed);
        logic [7:0] sum;
        for (int i = 0; i < 256; i++) begin
            if (i < 64) img[i] = 8'((i * 37) % 256);
            else        img[i] = 8'((i * 53 + seed * 29) % 256);
        end
        img[2]  = v.b2;
        img[3]  = v.b3;
        img[4]  = v.b4;
        img[17] = v.b17;
        for (int s = 0; s < 8; s++)
            img[slot_index(s)] = v.tbytes[63 - 8*s -: 8];
        sum = 8'h00;
        for (int i = 0; i < 63; i++) sum = sum + img[i];
        img[63] = v.good_sum ? sum : (sum ^ 8'h01);
    endtask

    task automatic stream(input int last_idx);
        for (int i = 0; i <= last_idx; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_index = 8'(i);
            byte_data  = img[i];
            byte_last  = (i == last_idx);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        byte_last  = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int k = 0;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk({req, " done within window"}, int'(done), 1);
    endtask

    task automatic check_image(input vec_t v, input string tag);
        chk({tag, " R2 csum_err"}, int'(csum_err), int'(v.exp_csum_err));
        chk({tag, " R3 type_err"}, int'(type_err), int'(v.exp_type_err));
        chk({tag, " R4 row_bits"}, int'(row_bits), int'(v.b3));
        chk({tag, " R4 col_bits"}, int'(col_bits), int'(v.b4));
        chk({tag, " R4 bank_count"}, int'(bank_count), int'(v.b17));
        for (int s = 0; s < 8; s++)
            chk({tag, " ", slot_req(s), " R8 clocks slot ", $sformatf("%0d", s)},
                got_clk(s), exp_clk(s, int'(v.tbytes[63 - 8*s -: 8])));
    endtask

    initial begin
        rst_n      = 1'b0;
        byte_valid = 1'b0;
        byte_index = 8'd0;
        byte_data  = 8'd0;
        byte_last  = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state.
        chk("R1 done", int'(done), 0);
        chk("R1 csum_err", int'(csum_err), 0);
        chk("R1 type_err", int'(type_err), 0);
        chk("R1 geometry", int'({row_bits, col_bits, bank_count}), 0);
        for (int s = 0; s < 8; s++) chk("R1 clocks", got_clk(s), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after release", int'(done), 0);

        // Table walk: full images with varied encodings and verdicts.
        for (int e = 0; e < 4; e++) begin
            build(VECS[e], 0);
            stream(255);
            wait_done("R9 table");
            check_image(VECS[e], $sformatf("vec%0d", e));
        end

        // R11: different upper-area bytes leave every output unchanged.
        build(VECS[0], 7);
        stream(255);
        wait_done("R11");
        check_image(VECS[0], "R11 upper bytes");

        // R10: done holds while idle, then an index-0 byte clears it.
        repeat (5) @(negedge clk);
        chk("R10 done held", int'(done), 1);
        byte_valid = 1'b1;
        byte_index = 8'd0;
        byte_data  = 8'h80;
        @(negedge clk);
        byte_valid = 1'b0;
        chk("R10 done cleared", int'(done), 0);
        chk("R10 flags cleared", int'({csum_err, type_err}), 0);

        // R9: an image ending before byte 63 never raises done.
        build(VECS[1], 0);
        stream(40);
        repeat (60) @(negedge clk);
        chk("R9 short image done", int'(done), 0);

        // R9: an image whose final byte is byte 63 completes.
        build(VECS[3], 0);
        stream(63);
        wait_done("R9 end at 63");
        check_image(VECS[3], "R9 end at 63");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule